// File: doc/BRIEF.md
# Strobed Serial Command Interface

This block is the host-facing receiver of a display and key-matrix controller. A host microcontroller talks to it over four wires: an active-low strobe that frames each transaction, a shift clock, a data input and an open-drain data output. All three inputs are brought into the system clock domain and sampled synchronously. Bits are taken least significant first on rising shift-clock edges.

The first byte after the strobe falls is always a command, and its two top bits pick one of four command classes. The mode command sets the grid/segment arrangement. The display-control command sets the on/off bit and the brightness code. The data-setting command chooses between writing display memory and reading key data, and between an incrementing and a fixed address. The address command loads the write pointer.

Bytes that follow a command are either written to display memory through a one-cycle write port or, in a read transaction, replaced by key bytes that the block shifts out. It selects each key byte through an index output, and the output changes on falling shift-clock edges. Raising the strobe ends a transaction at once and throws away any partial byte.

Top module: `strobe_cmd_if`

## Requirements
- R1: After reset, mode_sel is 2'b11, disp_ctrl is 4'h0, no write is issued, sdo_pull_low is 0, the write pointer is 0, and the data-setting configuration is write with auto-increment.
- R2: The first complete byte after ser_stb falls is a command. Its bits 7:6 select the class: 00 mode, 01 data setting, 10 display control, 11 address. Every later byte in the same transaction is data.
- R3: A mode command copies bits 1:0 into mode_sel and ignores bits 5:2. If the new value differs from the old one, disp_ctrl bit 3 (display on) is cleared. If it is the same, nothing changes.
- R4: A display-control command copies bits 3:0 into disp_ctrl, with bit 3 as display on and bits 2:0 as the brightness code.
- R5: Serial bits are taken least significant first on rising ser_clk edges. ser_clk is ignored while ser_stb is high.
- R6: If ser_stb rises before the eighth bit of a byte, that partial byte has no effect, and the next transaction starts with a fresh command byte.
- R7: In a data-setting command, bit 1 = 0 selects write and bit 2 = 0 selects auto-increment. Each data byte then produces one ram_we pulse at the current pointer, and the pointer then advances by one.
- R8: With data-setting bit 2 = 1, the pointer stays fixed, so every data byte is written to the same address.
- R9: The address command loads the pointer from bits 5:0. Only 0 to 13 are valid. A data byte at an invalid pointer, including one reached by incrementing past 13, is dropped without a ram_we pulse.
- R10: With data-setting bit 1 = 1, the transaction writes nothing. key_sel starts at 0 and key_rd pulses each time a key byte is selected. The selected key_byte is sent least significant bit first, one bit per falling ser_clk edge, with sdo_pull_low = 1 for a 0 bit. After 8 bits the next index is selected, and after index 4 the index wraps to 0.
- R11: sdo_pull_low is 0 whenever ser_stb is high or no read transaction is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_stb | input | 1 | Transaction strobe, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data in, LSB first |
| key_byte | input | 8 | Key data for the byte at key_sel |
| mode_sel | output | 2 | Display arrangement mode |
| disp_ctrl | output | 4 | Bit 3 display on, bits 2:0 brightness |
| ram_we | output | 1 | One-cycle display memory write |
| ram_addr | output | AW | Write address |
| ram_wdata | output | 8 | Write data |
| key_rd | output | 1 | Pulse when a key byte is selected |
| key_sel | output | KW | Index of the key byte being sent |
| sdo_pull_low | output | 1 | Pull the open-drain data line low |

## Verification
Single-byte commands are driven from a table that mixes mode changes, a repeated mode and display-control values. This separates class decoding, the ignored mode bits and the rule that a mode change switches the display off. Write transactions run with auto-increment, with a fixed address, from a pointer at the top of the valid range and from an invalid pointer, which tells incrementing, holding and dropping apart. A six-byte key read checks bit order, byte advance and index wraparound. Strobe aborts and clock toggles while the strobe is high show whether partial bytes and idle clocks leak into state.

// File: rtl/strobe_cmd_pkg.sv
// Shared definitions for the strobed serial command interface.
package strobe_cmd_pkg;
    // Command class carried in bits 7:6 of the first byte of a transaction.
    typedef enum logic [1:0] {
        CLS_MODE = 2'b00,
        CLS_DATA = 2'b01,
        CLS_DISP = 2'b10,
        CLS_ADDR = 2'b11
    } cmd_class_e;
endpackage

// File: rtl/strobe_if_sync.sv
// Brings strobe, shift clock and data into the clk domain through a
// chain of SYNC_STAGES flops and detects shift-clock edges.
// Assumes the host toggles its pins far slower than clk.
// Edges are reported only while the strobe is low.
module strobe_if_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_in,
    input  logic sclk_in,
    input  logic din_in,
    output logic stb_hi,
    output logic din_s,
    output logic sclk_rise,
    output logic sclk_fall
);
    // Each stage holds {strobe, shift clock, data}.
    logic [2:0] stage [SYNC_STAGES];
    logic       sclk_prev;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[i] <= 3'b110;
                else        stage[i] <= {stb_in, sclk_in, din_in};
            end
        end else begin : g_next
            // Later flops follow the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[i] <= 3'b110;
                else        stage[i] <= stage[i-1];
            end
        end
    end

    // Keep the previous synchronized shift clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b1;
        else        sclk_prev <= stage[SYNC_STAGES-1][1];
    end

    assign stb_hi    = stage[SYNC_STAGES-1][2];
    assign din_s     = stage[SYNC_STAGES-1][0];
    assign sclk_rise = !stb_hi &&  stage[SYNC_STAGES-1][1] && !sclk_prev;
    assign sclk_fall = !stb_hi && !stage[SYNC_STAGES-1][1] &&  sclk_prev;
endmodule

// File: rtl/strobe_byte_rx.sv
// Assembles LSB-first serial bits into bytes and flags the first byte
// of each transaction as a command. A high strobe clears the bit count.
module strobe_byte_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_hi,
    input  logic       bit_rise,
    input  logic       din,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       byte_is_cmd
);
    logic [6:0] sh_q;
    logic [2:0] cnt_q;
    logic       first_q;

    // Shift in bits and emit a one-cycle pulse for each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q        <= '0;
            cnt_q       <= '0;
            first_q     <= 1'b1;
            byte_valid  <= 1'b0;
            byte_data   <= '0;
            byte_is_cmd <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (stb_hi) begin
                cnt_q   <= '0;
                first_q <= 1'b1;
            end else if (bit_rise) begin
                cnt_q <= cnt_q + 3'd1;
                if (cnt_q == 3'd7) begin
                    byte_valid  <= 1'b1;
                    byte_data   <= {din, sh_q};
                    byte_is_cmd <= first_q;
                    first_q     <= 1'b0;
                end else begin
                    sh_q <= {din, sh_q[6:1]};
                end
            end
        end
    end
endmodule

// File: rtl/strobe_cmd_ctl.sv
// Decodes command bytes, holds the mode, display-control and
// data-setting state and the write pointer, and issues display memory
// writes for data bytes. Assumes at most one byte pulse per cycle.
module strobe_cmd_ctl
    import strobe_cmd_pkg::*;
#(
    parameter int         DEPTH    = 14,
    parameter logic [1:0] MODE_RST = 2'b11,
    localparam int        AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_hi,
    input  logic          byte_valid,
    input  logic [7:0]    byte_data,
    input  logic          byte_is_cmd,
    output logic [1:0]    mode_sel,
    output logic [3:0]    disp_ctrl,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata,
    output logic          rd_start,
    output logic          rd_active
);
    localparam int               PTR_W   = 6;
    localparam logic [PTR_W-1:0] PTR_LIM = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_MAX = '1;

    logic [PTR_W-1:0] ptr_q;
    logic             cfg_read_q;
    logic             cfg_fixed_q;
    logic             ptr_ok;

    assign ptr_ok = ptr_q < PTR_LIM;

    // Decode commands, store data bytes and track the read transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_sel    <= MODE_RST;
            disp_ctrl   <= '0;
            ptr_q       <= '0;
            cfg_read_q  <= 1'b0;
            cfg_fixed_q <= 1'b0;
            ram_we      <= 1'b0;
            ram_addr    <= '0;
            ram_wdata   <= '0;
            rd_start    <= 1'b0;
            rd_active   <= 1'b0;
        end else begin
            ram_we   <= 1'b0;
            rd_start <= 1'b0;
            if (byte_valid && byte_is_cmd) begin
                case (cmd_class_e'(byte_data[7:6]))
                    CLS_MODE: begin
                        if (byte_data[1:0] != mode_sel) begin
                            mode_sel     <= byte_data[1:0];
                            disp_ctrl[3] <= 1'b0;
                        end
                    end
                    CLS_DATA: begin
                        cfg_read_q  <= byte_data[1];
                        cfg_fixed_q <= byte_data[2];
                        rd_active   <= byte_data[1];
                        rd_start    <= byte_data[1];
                    end
                    CLS_DISP: disp_ctrl <= byte_data[3:0];
                    default:  ptr_q     <= byte_data[5:0];
                endcase
            end else if (byte_valid && !rd_active && !cfg_read_q) begin
                if (ptr_ok) begin
                    ram_we    <= 1'b1;
                    ram_addr  <= ptr_q[AW-1:0];
                    ram_wdata <= byte_data;
                end
                if (!cfg_fixed_q && ptr_q != PTR_MAX) ptr_q <= ptr_q + 1'b1;
            end
            if (stb_hi) rd_active <= 1'b0;
        end
    end
endmodule

// File: rtl/strobe_key_tx.sv
// Sends key bytes LSB first during a read transaction, changing the
// output bit on each falling shift-clock edge. Assumes key_byte follows
// key_sel combinationally and holds steady while a byte is sent.
module strobe_key_tx #(
    parameter int  KEY_BYTES = 5,
    localparam int KW        = $clog2(KEY_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_hi,
    input  logic          rd_start,
    input  logic          rd_active,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic [7:0]    key_byte,
    output logic [KW-1:0] key_sel,
    output logic          key_rd,
    output logic          sdo_pull_low
);
    localparam logic [KW-1:0] SEL_LAST = KW'(KEY_BYTES - 1);

    logic [2:0] bit_q;
    logic       drv_q;

    // Count bits on rising edges, step to the next byte and drive bits on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q   <= '0;
            drv_q   <= 1'b0;
            key_sel <= '0;
            key_rd  <= 1'b0;
        end else begin
            key_rd <= 1'b0;
            if (stb_hi) begin
                bit_q <= '0;
                drv_q <= 1'b0;
            end else if (rd_start) begin
                bit_q   <= '0;
                key_sel <= '0;
                key_rd  <= 1'b1;
            end else if (rd_active) begin
                if (sclk_rise) begin
                    bit_q <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        key_sel <= (key_sel == SEL_LAST) ? '0 : key_sel + 1'b1;
                        key_rd  <= 1'b1;
                    end
                end
                if (sclk_fall) drv_q <= !key_byte[bit_q];
            end
        end
    end

    assign sdo_pull_low = drv_q && rd_active && !stb_hi;
endmodule

// File: rtl/strobe_cmd_if.sv
// Top of the strobed serial command interface. It chains the input
// synchronizer, the byte receiver, the command decoder and the
// key-byte transmitter.
module strobe_cmd_if #(
    parameter int         DEPTH       = 14,
    parameter int         KEY_BYTES   = 5,
    parameter int         SYNC_STAGES = 2,
    parameter logic [1:0] MODE_RST    = 2'b11,
    localparam int        AW          = $clog2(DEPTH),
    localparam int        KW          = $clog2(KEY_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_stb,
    input  logic          ser_clk,
    input  logic          ser_din,
    input  logic [7:0]    key_byte,
    output logic [1:0]    mode_sel,
    output logic [3:0]    disp_ctrl,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata,
    output logic          key_rd,
    output logic [KW-1:0] key_sel,
    output logic          sdo_pull_low
);
    logic       stb_hi, din_s, sclk_rise, sclk_fall;
    logic       byte_valid, byte_is_cmd;
    logic [7:0] byte_data;
    logic       rd_start, rd_active;

    strobe_if_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .stb_in(ser_stb), .sclk_in(ser_clk),
        .din_in(ser_din), .stb_hi(stb_hi), .din_s(din_s),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
    );

    strobe_byte_rx u_rx (
        .clk(clk), .rst_n(rst_n), .stb_hi(stb_hi), .bit_rise(sclk_rise),
        .din(din_s), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_is_cmd(byte_is_cmd)
    );

    strobe_cmd_ctl #(.DEPTH(DEPTH), .MODE_RST(MODE_RST)) u_ctl (
        .clk(clk), .rst_n(rst_n), .stb_hi(stb_hi), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_is_cmd(byte_is_cmd),
        .mode_sel(mode_sel), .disp_ctrl(disp_ctrl), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .rd_start(rd_start), .rd_active(rd_active)
    );

    strobe_key_tx #(.KEY_BYTES(KEY_BYTES)) u_tx (
        .clk(clk), .rst_n(rst_n), .stb_hi(stb_hi), .rd_start(rd_start),
        .rd_active(rd_active), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .key_byte(key_byte), .key_sel(key_sel), .key_rd(key_rd),
        .sdo_pull_low(sdo_pull_low)
    );
endmodule

// File: rtl/strobe_cmd_if_chk.sv
// Property checker for strobe_cmd_if, attached through bind. It watches
// only the top-level ports.
module strobe_cmd_if_chk #(
    parameter int DEPTH = 14,
    parameter int AW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ser_stb,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr,
    input logic [1:0]    mode_sel,
    input logic [3:0]    disp_ctrl,
    input logic          key_rd,
    input logic          sdo_pull_low
);
    // R9: a write never targets an address outside display memory.
    assert_addr_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ({1'b0, ram_addr} < (AW+1)'(DEPTH)));

    // R11: a strobe held high releases the data line.
    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_stb && $past(ser_stb) && $past(ser_stb, 2)) |-> !sdo_pull_low);

    // R3: a change of mode always leaves the display switched off.
    assert_mode_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_sel) |-> !disp_ctrl[3]);

    // R7: each data byte produces a single-cycle write pulse.
    assert_write_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    // R10: key selection and memory writes never occur together.
    assert_read_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, key_rd}));
endmodule

bind strobe_cmd_if strobe_cmd_if_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_stb(ser_stb), .ram_we(ram_we),
    .ram_addr(ram_addr), .mode_sel(mode_sel), .disp_ctrl(disp_ctrl),
    .key_rd(key_rd), .sdo_pull_low(sdo_pull_low)
);

// File: tb/tb_strobe_cmd_if.sv
module tb_strobe_cmd_if;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_stb = 1'b1, ser_clk = 1'b1, ser_din = 1'b0;
    logic [7:0] key_byte;
    logic [1:0] mode_sel;
    logic [3:0] disp_ctrl;
    logic       ram_we, key_rd, sdo_pull_low;
    logic [3:0] ram_addr;
    logic [7:0] ram_wdata;
    logic [2:0] key_sel;

    int n_chk = 0, n_fail = 0;
    int wr_n = 0, krd_n = 0, stray = 0;
    logic [3:0] wa [32];
    logic [7:0] wd [32];
    logic rd_win = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    strobe_cmd_if dut (
        .clk(clk), .rst_n(rst_n), .ser_stb(ser_stb), .ser_clk(ser_clk),
        .ser_din(ser_din), .key_byte(key_byte), .mode_sel(mode_sel),
        .disp_ctrl(disp_ctrl), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .key_rd(key_rd), .key_sel(key_sel),
        .sdo_pull_low(sdo_pull_low)
    );

    function automatic logic [7:0] kval(input logic [2:0] s);
        return 8'h35 + {5'd0, s} * 8'h29;
    endfunction

    always_comb key_byte = kval(key_sel);

    // Port monitors: log writes, key selections and stray drive.
    always @(posedge clk) begin
        if (rst_n && ram_we && wr_n < 32) begin
            wa[wr_n] <= ram_addr;
            wd[wr_n] <= ram_wdata;
            wr_n     <= wr_n + 1;
        end
        if (rst_n && key_rd) krd_n <= krd_n + 1;
    end
    always @(negedge clk) if (rst_n && sdo_pull_low && !rd_win) stray <= stray + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b);
        @(negedge clk); ser_din = b; ser_clk = 1'b0;
        repeat (HALF) @(negedge clk);
        ser_clk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic sbyte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) sbit(v[i]);
    endtask

    task automatic rbyte(output logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); ser_clk = 1'b0;
            repeat (HALF) @(negedge clk);
            v[i] = ~sdo_pull_low;
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic begin_tx();
        @(negedge clk); ser_stb = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic end_tx();
        @(negedge clk); ser_stb = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] v);
        begin_tx(); sbyte(v); end_tx();
    endtask

    // {command byte, expected mode_sel, expected disp_ctrl}
    localparam logic [13:0] VEC [8] = '{
        {8'h8F, 2'd3, 4'hF},
        {8'h02, 2'd2, 4'h7},
        {8'h3E, 2'd2, 4'h7},
        {8'h8B, 2'd2, 4'hB},
        {8'h02, 2'd2, 4'hB},
        {8'h01, 2'd1, 4'h3},
        {8'h80, 2'd1, 4'h0},
        {8'h03, 2'd3, 4'h0}
    };

    initial begin
        logic [7:0] rb;
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk("R1 mode_sel", mode_sel, 2'b11);
        chk("R1 disp_ctrl", disp_ctrl, 4'h0);
        chk("R1 no write", wr_n, 0);
        chk("R11 released at reset", sdo_pull_low, 1'b0);

        // R1/R7: pointer 0 and write/auto-increment after reset
        begin_tx(); sbyte(8'h40); sbyte(8'h11); sbyte(8'h22); end_tx();
        chk("R1 R7 write count", wr_n, 2);
        chk("R1 first addr", wa[0], 4'd0);
        chk("R7 first data", wd[0], 8'h11);
        chk("R7 second addr", wa[1], 4'd1);
        chk("R7 second data", wd[1], 8'h22);

        // R2/R3/R4: command table
        foreach (VEC[i]) begin
            cmd1(VEC[i][13:6]);
            chk($sformatf("R2 R3 R4 vec%0d mode", i), mode_sel, VEC[i][5:4]);
            chk($sformatf("R2 R3 R4 vec%0d disp", i), disp_ctrl, VEC[i][3:0]);
        end

        // R5: clock toggles while strobe high are ignored
        ser_din = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ser_clk = 1'b0;
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        cmd1(8'h85);
        chk("R5 idle clocks ignored", disp_ctrl, 4'h5);

        // R6: aborted command byte
        begin_tx();
        for (int i = 0; i < 4; i++) sbit(1'(8'h8A >> i));
        end_tx();
        chk("R6 partial command dropped", disp_ctrl, 4'h5);
        // R6: aborted data byte after a complete one
        base = wr_n;
        begin_tx(); sbyte(8'hC3); sbyte(8'hAA);
        for (int i = 0; i < 3; i++) sbit(1'b1);
        end_tx();
        chk("R6 only whole byte written", wr_n - base, 1);
        chk("R6 whole byte addr", wa[base], 4'd3);
        chk("R6 whole byte data", wd[base], 8'hAA);
        cmd1(8'h8C);
        chk("R6 fresh command after abort", disp_ctrl, 4'hC);

        // R8: fixed address
        cmd1(8'h44);
        base = wr_n;
        begin_tx(); sbyte(8'hC7); sbyte(8'h5A); sbyte(8'hA5); end_tx();
        chk("R8 write count", wr_n - base, 2);
        chk("R8 addr held", {wa[base], wa[base+1]}, {4'd7, 4'd7});
        chk("R8 last data", wd[base+1], 8'hA5);

        // R9: invalid address drops, incrementing past 13 drops
        cmd1(8'h40);
        base = wr_n;
        begin_tx(); sbyte(8'hCE); sbyte(8'h01); sbyte(8'h02); end_tx();
        chk("R9 invalid addr no write", wr_n - base, 0);
        begin_tx(); sbyte(8'hCC); sbyte(8'h61); sbyte(8'h62); sbyte(8'h63); end_tx();
        chk("R9 top of range count", wr_n - base, 2);
        chk("R9 addr 12/13", {wa[base], wa[base+1]}, {4'd12, 4'd13});
        chk("R9 data 12/13", {wd[base], wd[base+1]}, {8'h61, 8'h62});

        // R10: key read of six bytes with wraparound
        base  = wr_n;
        krd_n = 0;
        rd_win = 1'b1;
        begin_tx(); sbyte(8'h42);
        repeat (2*HALF) @(negedge clk);
        for (int b = 0; b < 6; b++) begin
            rbyte(rb);
            chk($sformatf("R10 key byte %0d", b), rb, kval(3'(b % 5)));
        end
        end_tx();
        rd_win = 1'b0;
        chk("R10 no write in read", wr_n - base, 0);
        chk("R10 key_rd pulses", krd_n, 7);
        chk("R10 key_sel wrapped", key_sel, 3'd1);
        chk("R11 released after read", sdo_pull_low, 1'b0);
        chk("R11 no stray drive", stray, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule